// File: doc/BRIEF.md
# Video Timing Reference Code Inserter

This block sits in a 10-bit parallel component video path. It writes timing reference codes into the word stream. Normally every input word reaches the output one enabled clock later, unchanged. When the code strobe is taken, the next four output words are replaced by a fixed preamble of all ones, zero and zero, followed by a status word. The status word carries the field, vertical-blanking and horizontal-blanking flags and a set of protection bits. A status word with the horizontal flag set marks the end of active video. A status word with that flag clear marks the start of active video.

A format input picks how the status word is laid out. The normal layout is for ordinary component video. The four-component layout carries one extra status bit and uses a different set of protection bits. A second strobe writes the three-word ancillary data flag preamble instead of a timing code. An output flag marks the first word of every inserted symbol. Every register advances only on cycles where the clock enable is high.

Top module: `trc_inserter`

## Requirements
- R1: While reset is high at a clock edge, word_out becomes 0 and first_out becomes 0.
- R2: When no symbol is being inserted, word_out equals the word_in value that was present at the previous enabled edge, and first_out is 0.
- R3: When start_code is taken (ce high, no insertion in progress), word_out shows 3FF, 000, 000 and then the status word on four consecutive enabled edges. The first of these edges is the one that takes the strobe. first_out is 1 only with the 3FF word.
- R4: Normal-format status word (fmt_4444_in = 0): bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1:0 = 0. H = 1 marks end of active video and H = 0 marks start of active video.
- R5: Four-component status word (fmt_4444_in = 1): bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = S, bit 4 = F^V^H, bit 3 = F^V^S, bit 2 = V^H^S, bit 1 = F^H^S, and bit 0 = 0.
- R6: F, V, H, S and the format select are captured at the edge that takes the start strobe. Changing them later in the symbol does not change the status word.
- R7: When start_anc is taken, word_out shows 000, 3FF, 3FF on three consecutive enabled edges, and first_out is 1 only with the first word.
- R8: A start_code or start_anc that arrives while an insertion is still in progress has no effect. This includes the edge that loads the last word of a symbol.
- R9: While ce is low, word_out and first_out hold their values, and strobes are not taken.
- R10: If start_code and start_anc are both high at an edge where a strobe can be taken, the timing code is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all registers |
| word_in | input | 10 | Incoming video word |
| start_code | input | 1 | Request a timing reference code |
| start_anc | input | 1 | Request an ancillary data flag preamble |
| fld_in | input | 1 | Field flag F |
| vblank_in | input | 1 | Vertical blanking flag V |
| hblank_in | input | 1 | Horizontal blanking flag H |
| ext_in | input | 1 | Extra status bit S (four-component format) |
| fmt_4444_in | input | 1 | 1 selects the four-component status layout |
| word_out | output | 10 | Outgoing video word |
| first_out | output | 1 | High with the first word of an inserted symbol |

## Verification
The status encoder is driven with all eight F/V/H combinations in normal format and all sixteen F/V/H/S combinations in the four-component format. This shows that each protection bit follows its own parity term and that the extra bit moves bit 5 and the layout. The flags and the format select are flipped after each strobe, which separates capture at the strobe from use of live values. Strobes are also sent while a symbol is in progress (on a middle word and on the last word), while the clock enable is low, and together with the other strobe. These runs tell correct masking and priority apart from a restart or a swapped preamble. Passthrough words with distinct values around each symbol confirm the one-cycle latency and show that no input word leaks into an inserted symbol.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic {
    SYM_CODE = 1'b0,
    SYM_ANC  = 1'b1
  } sym_t;

  typedef struct packed {
    logic fld;
    logic vbl;
    logic hbl;
    logic ext;
    logic wide;
  } flags_t;

endpackage

// File: rtl/trc_status_enc.sv
module trc_status_enc
  import trc_pkg::*;
#(
  parameter int DW = 10
) (
  input  flags_t        flags,
  output logic [DW-1:0] status
);
  localparam int TOP = DW - 1;

  logic f, v, h, s;
  assign f = flags.fld;
  assign v = flags.vbl;
  assign h = flags.hbl;
  assign s = flags.ext;

  always_comb begin
    status        = '0;
    status[TOP]   = 1'b1;
    status[TOP-1] = f;
    status[TOP-2] = v;
    status[TOP-3] = h;
    if (flags.wide) begin
      status[TOP-4] = s;
      status[TOP-5] = f ^ v ^ h;
      status[TOP-6] = f ^ v ^ s;
      status[TOP-7] = v ^ h ^ s;
      status[TOP-8] = f ^ h ^ s;
    end else begin
      status[TOP-4] = v ^ h;
      status[TOP-5] = f ^ h;
      status[TOP-6] = f ^ v;
      status[TOP-7] = f ^ v ^ h;
    end
  end
endmodule

// File: rtl/trc_seq.sv
module trc_seq
  import trc_pkg::*;
#(
  parameter int CODE_LEN = 4,
  parameter int ANC_LEN  = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   ce,
  input  logic   start_code,
  input  logic   start_anc,
  input  flags_t flags_in,
  output logic   sel_valid,
  output sym_t   sel_kind,
  output logic [$clog2(CODE_LEN)-1:0] sel_idx,
  output logic   sel_first,
  output flags_t flags_q
);
  localparam int IDX_W = $clog2(CODE_LEN);
  localparam logic [IDX_W-1:0] CODE_LAST = IDX_W'(CODE_LEN - 1);
  localparam logic [IDX_W-1:0] ANC_LAST  = IDX_W'(ANC_LEN - 1);

  logic             busy;
  logic [IDX_W-1:0] cnt;
  sym_t             kind;
  logic             accept;
  logic             last;

  assign accept = ce && !busy && (start_code || start_anc);
  assign last   = (kind == SYM_CODE) ? (cnt == CODE_LAST) : (cnt == ANC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      kind    <= SYM_CODE;
      flags_q <= '0;
    end else if (ce) begin
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= IDX_W'(1);
        kind    <= start_code ? SYM_CODE : SYM_ANC;
        flags_q <= flags_in;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    sel_valid = accept || busy;
    sel_first = accept;
    if (accept) begin
      sel_kind = start_code ? SYM_CODE : SYM_ANC;
      sel_idx  = '0;
    end else begin
      sel_kind = kind;
      sel_idx  = cnt;
    end
  end

  // R6: captured flags do not move while a symbol is in progress
  assert_flags_held_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(flags_q));

  // R8: a symbol in progress advances by one word, strobes notwithstanding
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (ce && busy && !last) |=> (busy && cnt == $past(cnt) + IDX_W'(1)));

  // R10: simultaneous strobes yield a timing code
  assert_code_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (ce && !busy && start_code && start_anc) |=> (kind == SYM_CODE));
endmodule

// File: rtl/trc_out_stage.sv
module trc_out_stage
  import trc_pkg::*;
#(
  parameter int DW    = 10,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [DW-1:0]    word_in,
  input  logic             sel_valid,
  input  sym_t             sel_kind,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             sel_first,
  input  logic [DW-1:0]    status,
  output logic [DW-1:0]    word_out,
  output logic             first_out
);
  localparam int TOP = DW - 1;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic [DW-1:0] ins_word;

  always_comb begin
    if (sel_kind == SYM_CODE) begin
      if (sel_idx == IDX_W'(0))      ins_word = ONES;
      else if (sel_idx == IDX_W'(3)) ins_word = status;
      else                           ins_word = ZEROS;
    end else begin
      ins_word = (sel_idx == IDX_W'(0)) ? ZEROS : ONES;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out  <= '0;
      first_out <= 1'b0;
    end else if (ce) begin
      word_out  <= sel_valid ? ins_word : word_in;
      first_out <= sel_first;
    end
  end

  // R2: passthrough with one enabled cycle of latency
  assert_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && !sel_valid) |=> (word_out == $past(word_in) && !first_out));

  // R3: a first-word marker always carries a preamble word
  assert_first_word_R3: assert property (@(posedge clk) disable iff (rst)
    first_out |-> ((&word_out[TOP -: 8]) || !(|word_out[TOP -: 8])));

  // R9: no change while the clock enable is low
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(word_out) && $stable(first_out)));
endmodule

// File: rtl/trc_inserter.sv
module trc_inserter
  import trc_pkg::*;
#(
  parameter int DW       = 10,
  parameter int CODE_LEN = 4,
  parameter int ANC_LEN  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [DW-1:0] word_in,
  input  logic          start_code,
  input  logic          start_anc,
  input  logic          fld_in,
  input  logic          vblank_in,
  input  logic          hblank_in,
  input  logic          ext_in,
  input  logic          fmt_4444_in,
  output logic [DW-1:0] word_out,
  output logic          first_out
);
  localparam int IDX_W = $clog2(CODE_LEN);
  localparam int TOP   = DW - 1;

  flags_t           flags_in;
  flags_t           flags_q;
  logic             sel_valid;
  sym_t             sel_kind;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_first;
  logic [DW-1:0]    status;

  assign flags_in = '{fld: fld_in, vbl: vblank_in, hbl: hblank_in,
                      ext: ext_in, wide: fmt_4444_in};

  trc_seq #(.CODE_LEN(CODE_LEN), .ANC_LEN(ANC_LEN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .start_code (start_code),
    .start_anc  (start_anc),
    .flags_in   (flags_in),
    .sel_valid  (sel_valid),
    .sel_kind   (sel_kind),
    .sel_idx    (sel_idx),
    .sel_first  (sel_first),
    .flags_q    (flags_q)
  );

  trc_status_enc #(.DW(DW)) u_enc (
    .flags  (flags_q),
    .status (status)
  );

  trc_out_stage #(.DW(DW), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .word_in   (word_in),
    .sel_valid (sel_valid),
    .sel_kind  (sel_kind),
    .sel_idx   (sel_idx),
    .sel_first (sel_first),
    .status    (status),
    .word_out  (word_out),
    .first_out (first_out)
  );

  // R4: the loaded status word always carries its fixed top bit
  assert_status_marker_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && sel_valid && sel_kind == SYM_CODE && sel_idx == IDX_W'(CODE_LEN - 1))
      |=> (word_out[TOP] && !first_out));
endmodule

// File: tb/test_trc_inserter.sv
module test_trc_inserter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic [9:0] word_in = '0;
  logic       start_code = 1'b0;
  logic       start_anc = 1'b0;
  logic       fld_in = 1'b0, vblank_in = 1'b0, hblank_in = 1'b0;
  logic       ext_in = 1'b0, fmt_4444_in = 1'b0;
  logic [9:0] word_out;
  logic       first_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trc_inserter i_trc_inserter (
    .clk(clk), .rst(rst), .ce(ce), .word_in(word_in),
    .start_code(start_code), .start_anc(start_anc),
    .fld_in(fld_in), .vblank_in(vblank_in), .hblank_in(hblank_in),
    .ext_in(ext_in), .fmt_4444_in(fmt_4444_in),
    .word_out(word_out), .first_out(first_out)
  );

  function automatic logic [9:0] exp_status(logic f, logic v, logic h,
                                             logic s, logic m);
    if (m) return {1'b1, f, v, h, s, f^v^h, f^v^s, v^h^s, f^h^s, 1'b0};
    else   return {1'b1, f, v, h, v^h, f^h, f^v, f^v^h, 2'b00};
  endfunction

  task automatic chk(string req, logic [9:0] act_w, logic act_f,
                     logic [9:0] exp_w, logic exp_f);
    checks++;
    if (act_w !== exp_w || act_f !== exp_f) begin
      errors++;
      $display("FAIL %s: word_out=%h first_out=%b expected word_out=%h first_out=%b",
               req, act_w, act_f, exp_w, exp_f);
    end
  endtask

  // drive inputs, pass one edge, then sample 1 ns after it
  task automatic cyc(logic [9:0] w, logic sc, logic sa, logic en);
    word_in = w; start_code = sc; start_anc = sa; ce = en;
    @(posedge clk); #1;
  endtask

  task automatic set_flags(logic f, logic v, logic h, logic s, logic m);
    fld_in = f; vblank_in = v; hblank_in = h; ext_in = s; fmt_4444_in = m;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(10'h155, 1'b1, 1'b0, 1'b1);
    cyc(10'h2AA, 1'b0, 1'b1, 1'b1);
    chk("R1 reset", word_out, first_out, 10'h000, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_pass;
    for (int i = 0; i < 6; i++) begin
      logic [9:0] w = 10'(37 * i + 5) ^ 10'h2C3;
      cyc(w, 1'b0, 1'b0, 1'b1);
      chk("R2 passthrough", word_out, first_out, w, 1'b0);
    end
  endtask

  task automatic t_code(logic f, logic v, logic h, logic s, logic m);
    logic [9:0] st = exp_status(f, v, h, s, m);
    set_flags(f, v, h, s, m);
    cyc(10'h0F1, 1'b1, 1'b0, 1'b1);
    chk("R3 word 3FF", word_out, first_out, 10'h3FF, 1'b1);
    set_flags(!f, !v, !h, !s, !m);
    cyc(10'h3FE, 1'b0, 1'b0, 1'b1);
    chk("R3 word 000", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h3FD, 1'b0, 1'b0, 1'b1);
    chk("R3 word 000", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h3FC, 1'b0, 1'b0, 1'b1);
    chk(m ? "R5 R6 status 4444" : "R4 R6 status normal", word_out, first_out, st, 1'b0);
    cyc(10'h123, 1'b0, 1'b0, 1'b1);
    chk("R2 after code", word_out, first_out, 10'h123, 1'b0);
  endtask

  task automatic t_anc;
    cyc(10'h0AB, 1'b0, 1'b1, 1'b1);
    chk("R7 anc 000", word_out, first_out, 10'h000, 1'b1);
    cyc(10'h0AC, 1'b0, 1'b0, 1'b1);
    chk("R7 anc 3FF", word_out, first_out, 10'h3FF, 1'b0);
    cyc(10'h0AD, 1'b0, 1'b0, 1'b1);
    chk("R7 anc 3FF", word_out, first_out, 10'h3FF, 1'b0);
    cyc(10'h0AE, 1'b0, 1'b0, 1'b1);
    chk("R2 after anc", word_out, first_out, 10'h0AE, 1'b0);
  endtask

  task automatic t_busy;
    set_flags(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(10'h011, 1'b1, 1'b0, 1'b1);
    chk("R8 start", word_out, first_out, 10'h3FF, 1'b1);
    cyc(10'h012, 1'b0, 1'b1, 1'b1);
    chk("R8 anc strobe ignored", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h013, 1'b1, 1'b0, 1'b1);
    chk("R8 code strobe ignored", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h014, 1'b1, 1'b1, 1'b1);
    chk("R8 strobe on last word ignored", word_out, first_out,
        exp_status(1'b1, 1'b0, 1'b1, 1'b0, 1'b0), 1'b0);
    cyc(10'h015, 1'b0, 1'b1, 1'b1);
    chk("R8 new anc taken after end", word_out, first_out, 10'h000, 1'b1);
    cyc(10'h016, 1'b1, 1'b0, 1'b1);
    chk("R8 code strobe in anc ignored", word_out, first_out, 10'h3FF, 1'b0);
    cyc(10'h017, 1'b1, 1'b0, 1'b1);
    chk("R8 strobe on anc last word ignored", word_out, first_out, 10'h3FF, 1'b0);
    cyc(10'h018, 1'b0, 1'b0, 1'b1);
    chk("R8 passthrough after", word_out, first_out, 10'h018, 1'b0);
  endtask

  task automatic t_ce;
    cyc(10'h2B7, 1'b0, 1'b0, 1'b1);
    cyc(10'h0C0, 1'b1, 1'b1, 1'b0);
    chk("R9 hold, strobe not taken", word_out, first_out, 10'h2B7, 1'b0);
    cyc(10'h0C1, 1'b0, 1'b0, 1'b1);
    chk("R9 no symbol after gated strobe", word_out, first_out, 10'h0C1, 1'b0);
    set_flags(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    cyc(10'h0C2, 1'b1, 1'b0, 1'b1);
    chk("R9 code start", word_out, first_out, 10'h3FF, 1'b1);
    cyc(10'h0C3, 1'b0, 1'b0, 1'b0);
    chk("R9 stall keeps first word", word_out, first_out, 10'h3FF, 1'b1);
    cyc(10'h0C4, 1'b0, 1'b0, 1'b0);
    chk("R9 stall keeps first word", word_out, first_out, 10'h3FF, 1'b1);
    cyc(10'h0C5, 1'b0, 1'b0, 1'b1);
    chk("R9 resume 000", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h0C6, 1'b0, 1'b0, 1'b1);
    chk("R9 resume 000", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h0C7, 1'b0, 1'b0, 1'b1);
    chk("R9 resume status", word_out, first_out,
        exp_status(1'b0, 1'b1, 1'b0, 1'b1, 1'b1), 1'b0);
  endtask

  task automatic t_both;
    set_flags(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(10'h101, 1'b1, 1'b1, 1'b1);
    chk("R10 both strobes give code", word_out, first_out, 10'h3FF, 1'b1);
    cyc(10'h102, 1'b0, 1'b0, 1'b1);
    chk("R10 second word", word_out, first_out, 10'h000, 1'b0);
    cyc(10'h103, 1'b0, 1'b0, 1'b1);
    cyc(10'h104, 1'b0, 1'b0, 1'b1);
    chk("R10 status", word_out, first_out,
        exp_status(1'b1, 1'b1, 1'b0, 1'b0, 1'b0), 1'b0);
  endtask

  initial begin
    #2;
    t_reset();
    t_pass();
    for (int k = 0; k < 8; k++) t_code(k[2], k[1], k[0], 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) t_code(k[3], k[2], k[1], k[0], 1'b1);
    t_anc();
    t_busy();
    t_ce();
    t_both();
    t_pass();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule